// File: doc/BRIEF.md
# External Memory Strobe Timing Sequencer

This block runs one access at a time to an external asynchronous memory or flash device. A bus-side master raises a request with a read/write flag, an address and write data. The sequencer then drives an active-low chip select and either an active-low output-enable (reads) or an active-low write-enable (writes). It holds the address and, for writes, the data bus for the whole access. When the access is complete it returns a one-cycle acknowledge, and for reads it also returns the captured read data.

Three timing counts set the access shape, and they are captured when the request is taken:
- a lead-in count: cycles with the chip select low before the strobe falls;
- a strobe count: the strobe stays low for that value plus one cycles;
- a tail count: cycles with the chip select still low after the strobe rises.

A device ready/busy line can optionally extend the strobe until the device reports completion. A polarity select picks what that line means: 0 treats it as a ready line, where high means done; 1 treats it as a busy line, where low means done. The line passes through a two-flop synchronizer before the sequencer uses it.

Top module: `ext_strobe_seq`

## Requirements
- R1: While reset is asserted, chip select, output-enable and write-enable are high, acknowledge is low and the data bus is not driven.
- R2: A request seen in the idle state is accepted at that clock edge, and chip select is low in the very next cycle. Requests seen while an access is in progress are ignored.
- R3: The number of cycles in which chip select is low and the strobe is still high before the strobe falls equals the captured lead-in count, from 0 to 7. A count of 0 makes the strobe fall together with chip select.
- R4: With ready monitoring off, the strobe stays low for the captured strobe count plus one cycles, from 1 to 16 cycles. The ready/busy line has no effect in this mode.
- R5: The number of cycles in which the strobe is high and chip select is still low after the strobe rises equals the captured tail count, from 0 to 7.
- R6: A read (flag 0) uses only output-enable. A write (flag 1) uses only write-enable. The two strobes are never low together.
- R7: Acknowledge is high for exactly one cycle, and that cycle is the first one in which chip select is high again after the access.
- R8: After a read, the read data output holds the value on the data bus during the last cycle in which output-enable was low. A write leaves the read data output unchanged.
- R9: For the whole time chip select is low, the address output equals the request address. For a write, the data bus also carries the request data for that whole time.
- R10: With ready monitoring on and polarity 0, the strobe stays low until the ready line has been high for the synchronizer delay. If the line rises at the negative edge after the k-th low strobe cycle, the strobe stays low for max(count+1, k+2) cycles.
- R11: With ready monitoring on and polarity 1, the same rule as R10 applies, except that the access waits for the busy line to go low.
- R12: The read/write flag, address, write data, timing counts and ready settings are captured when the request is accepted. Changing them during the access has no effect on that access.
- R13: With ready monitoring on and the device already reporting done, the strobe length is exactly the strobe count plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| lead_i | input | LEAD_W | Lead-in cycles (chip select to strobe) |
| strobe_i | input | STRB_W | Strobe count; strobe is low for this value plus one |
| tail_i | input | TAIL_W | Tail cycles (strobe rise to chip select rise) |
| rdy_en_i | input | 1 | Enable ready/busy wait |
| rdy_pol_i | input | 1 | 0 = ready line (wait for high), 1 = busy line (wait for low) |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_addr_o | output | AW | Device address |
| mem_data_io | inout | DW | Device data bus |
| mem_rb_i | input | 1 | Device ready/busy line (asynchronous) |

## Verification
A wrong phase counter or a skipped phase shows up as a lead-in, strobe or tail length that is off by at least one cycle. The bench measures each of these cycle by cycle during every access, so the error is caught in that same access. If the phase state register holds a wrong value, one of three things becomes visible before acknowledge: both strobes low together, the wrong strobe for the access type, or chip select rising early. If the ready path is wrong, the strobe length differs from the max(count+1, k+2) rule, and an inverted polarity leaves the access stuck until the watchdog expires. If capture is wrong, the address, the write data or the read data differs from the values taken at acceptance, and this is checked on every cycle of every access while the bench scrambles the request inputs.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LEAD  = 3'd1,
      PH_STRB  = 3'd2,
      PH_WAIT  = 3'd3,
      PH_TAIL  = 3'd4,
      PH_DONE  = 3'd5
   } phase_e;

   function automatic logic phase_busy(input phase_e ph);
      return (ph == PH_LEAD) || (ph == PH_STRB) || (ph == PH_WAIT) || (ph == PH_TAIL);
   endfunction

   function automatic logic phase_strobe(input phase_e ph);
      return (ph == PH_STRB) || (ph == PH_WAIT);
   endfunction

endpackage

// File: rtl/memseq_sync.sv
module memseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("memseq_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} & {STAGES{1'b1}};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/memseq_phase_cnt.sv
module memseq_phase_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad
         $error("memseq_phase_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/memseq_ctrl.sv
module memseq_ctrl
   import memseq_pkg::*;
#(
   parameter int LEAD_W = 3,
   parameter int STRB_W = 4,
   parameter int TAIL_W = 3,
   parameter int CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [LEAD_W-1:0] lead_i,
   input  logic [STRB_W-1:0] strb_i,
   input  logic [TAIL_W-1:0] tail_i,
   input  logic              rdy_en_i,
   input  logic              ready_ok_i,
   input  logic              cnt_zero_i,
   output logic              cnt_load_o,
   output logic [CW-1:0]     cnt_val_o,
   output logic              accept_o,
   output logic              strobe_end_o,
   output phase_e            phase_o
);

   phase_e phase_q, phase_d;
   logic   strb_release;

   generate
      if (CW < LEAD_W || CW < STRB_W || CW < TAIL_W) begin : g_bad
         $error("memseq_ctrl: CW narrower than a timing field");
      end
   endgenerate

   assign strb_release = ((phase_q == PH_STRB) && cnt_zero_i && (!rdy_en_i || ready_ok_i)) ||
                         ((phase_q == PH_WAIT) && ready_ok_i);

   always_comb begin
      phase_d    = phase_q;
      cnt_load_o = 1'b0;
      cnt_val_o  = '0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_i) begin
               cnt_load_o = 1'b1;
               if (lead_i != '0) begin
                  phase_d   = PH_LEAD;
                  cnt_val_o = CW'(lead_i) - CW'(1);
               end else begin
                  phase_d   = PH_STRB;
                  cnt_val_o = CW'(strb_i);
               end
            end
         end
         PH_LEAD: begin
            if (cnt_zero_i) begin
               phase_d    = PH_STRB;
               cnt_load_o = 1'b1;
               cnt_val_o  = CW'(strb_i);
            end
         end
         PH_STRB, PH_WAIT: begin
            if (strb_release) begin
               if (tail_i != '0) begin
                  phase_d    = PH_TAIL;
                  cnt_load_o = 1'b1;
                  cnt_val_o  = CW'(tail_i) - CW'(1);
               end else begin
                  phase_d = PH_DONE;
               end
            end else if (phase_q == PH_STRB && cnt_zero_i) begin
               phase_d = PH_WAIT;
            end
         end
         PH_TAIL: begin
            if (cnt_zero_i) phase_d = PH_DONE;
         end
         PH_DONE: phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign accept_o     = (phase_q == PH_IDLE) && req_i;
   assign strobe_end_o = strb_release;
   assign phase_o      = phase_q;

endmodule

// File: rtl/ext_strobe_seq.sv
module ext_strobe_seq
   import memseq_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int LEAD_W      = 3,
   parameter int STRB_W      = 4,
   parameter int TAIL_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [LEAD_W-1:0] lead_i,
   input  logic [STRB_W-1:0] strobe_i,
   input  logic [TAIL_W-1:0] tail_i,
   input  logic              rdy_en_i,
   input  logic              rdy_pol_i,
   output logic              ack_o,
   output logic [DW-1:0]     rdata_o,
   output logic              mem_cs_n_o,
   output logic              mem_oe_n_o,
   output logic              mem_we_n_o,
   output logic [AW-1:0]     mem_addr_o,
   inout  wire  [DW-1:0]     mem_data_io,
   input  logic              mem_rb_i
);

   localparam int CW_A = (LEAD_W > STRB_W) ? LEAD_W : STRB_W;
   localparam int CW   = (CW_A > TAIL_W) ? CW_A : TAIL_W;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_bus
         $error("ext_strobe_seq: bus widths must be positive");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("ext_strobe_seq: a single synchronizer stage is not allowed");
      end
   endgenerate

   // captured access context
   logic              we_q;
   logic [AW-1:0]     addr_q;
   logic [DW-1:0]     wdata_q;
   logic [LEAD_W-1:0] lead_q;
   logic [STRB_W-1:0] strb_q;
   logic [TAIL_W-1:0] tail_q;
   logic              rdy_en_q;
   logic              rdy_pol_q;
   logic [DW-1:0]     rdata_q;

   logic              rb_sync;
   logic              ready_ok;
   logic              cnt_load;
   logic [CW-1:0]     cnt_val;
   logic              cnt_zero;
   logic              accept;
   logic              strobe_end;
   phase_e            phase;

   logic [LEAD_W-1:0] lead_sel;
   logic [STRB_W-1:0] strb_sel;
   logic [TAIL_W-1:0] tail_sel;
   logic              rdy_en_sel;
   logic              busy;
   logic              strobing;
   logic              drive_bus;

   memseq_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (mem_rb_i),
      .q_o   (rb_sync)
   );

   assign ready_ok = rdy_pol_q ? ~rb_sync : rb_sync;

   // in idle the live inputs steer the first phase; afterwards the captured copy
   always_comb begin
      if (phase == PH_IDLE) begin
         lead_sel   = lead_i;
         strb_sel   = strobe_i;
         tail_sel   = tail_i;
         rdy_en_sel = rdy_en_i;
      end else begin
         lead_sel   = lead_q;
         strb_sel   = strb_q;
         tail_sel   = tail_q;
         rdy_en_sel = rdy_en_q;
      end
   end

   memseq_ctrl #(
      .LEAD_W (LEAD_W),
      .STRB_W (STRB_W),
      .TAIL_W (TAIL_W),
      .CW     (CW)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .lead_i       (lead_sel),
      .strb_i       (strb_sel),
      .tail_i       (tail_sel),
      .rdy_en_i     (rdy_en_sel),
      .ready_ok_i   (ready_ok),
      .cnt_zero_i   (cnt_zero),
      .cnt_load_o   (cnt_load),
      .cnt_val_o    (cnt_val),
      .accept_o     (accept),
      .strobe_end_o (strobe_end),
      .phase_o      (phase)
   );

   memseq_phase_cnt #(.W(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_load),
      .load_val_i (cnt_val),
      .zero_o     (cnt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         lead_q    <= '0;
         strb_q    <= '0;
         tail_q    <= '0;
         rdy_en_q  <= 1'b0;
         rdy_pol_q <= 1'b0;
      end else if (accept) begin
         we_q      <= we_i;
         addr_q    <= addr_i;
         wdata_q   <= wdata_i;
         lead_q    <= lead_i;
         strb_q    <= strobe_i;
         tail_q    <= tail_i;
         rdy_en_q  <= rdy_en_i;
         rdy_pol_q <= rdy_pol_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rdata_q <= '0;
      else if (strobe_end && !we_q) rdata_q <= mem_data_io;
   end

   assign busy      = phase_busy(phase);
   assign strobing  = phase_strobe(phase);
   assign drive_bus = busy && we_q;

   assign mem_cs_n_o  = ~busy;
   assign mem_oe_n_o  = ~(strobing && !we_q);
   assign mem_we_n_o  = ~(strobing && we_q);
   assign mem_addr_o  = addr_q;
   assign mem_data_io = drive_bus ? wdata_q : {DW{1'bz}};
   assign ack_o       = (phase == PH_DONE);
   assign rdata_o     = rdata_q;

endmodule

// File: rtl/memseq_chk.sv
module memseq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          oe_n,
   input logic          we_n,
   input logic          ack,
   input logic [AW-1:0] addr
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (cs_n && oe_n && we_n && !ack); // R1
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n)); // R6

   AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n || !we_n) |-> !cs_n); // R3

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R7

   AST_ACK_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (cs_n && $past(!cs_n))); // R7

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(addr)); // R9

   AST_STROBE_RISE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oe_n) || $rose(we_n)) |-> (!cs_n || ack)); // R5

endmodule

bind ext_strobe_seq memseq_chk #(.AW(AW)) u_memseq_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (mem_cs_n_o),
   .oe_n  (mem_oe_n_o),
   .we_n  (mem_we_n_o),
   .ack   (ack_o),
   .addr  (mem_addr_o)
);

// File: tb/test_ext_strobe_seq.sv
module test_ext_strobe_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic          we_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic [2:0]    lead_i = '0;
   logic [3:0]    strobe_i = '0;
   logic [2:0]    tail_i = '0;
   logic          rdy_en_i = 1'b0;
   logic          rdy_pol_i = 1'b0;
   logic          mem_rb_i = 1'b0;
   logic          ack_o;
   logic [DW-1:0] rdata_o;
   logic          mem_cs_n_o, mem_oe_n_o, mem_we_n_o;
   logic [AW-1:0] mem_addr_o;
   wire  [DW-1:0] mem_data_io;
   logic          bus_drv = 1'b0;
   logic [DW-1:0] bus_val = '0;

   assign mem_data_io = bus_drv ? bus_val : {DW{1'bz}};

   int n_checks = 0;
   int n_fail = 0;
   logic [DW-1:0] exp_rdata = '0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_strobe_seq #(.AW(AW), .DW(DW)) i_ext_strobe_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .lead_i(lead_i), .strobe_i(strobe_i), .tail_i(tail_i),
      .rdy_en_i(rdy_en_i), .rdy_pol_i(rdy_pol_i), .ack_o(ack_o), .rdata_o(rdata_o),
      .mem_cs_n_o(mem_cs_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o),
      .mem_addr_o(mem_addr_o), .mem_data_io(mem_data_io), .mem_rb_i(mem_rb_i)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_strobe_len(input int cnt, input bit ren, input int rel_at);
      if (ren && rel_at != 0) return (cnt + 1 > rel_at + 2) ? cnt + 1 : rel_at + 2;
      return cnt + 1;
   endfunction

   task automatic run_access(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                             input int ld, input int sb, input int tl,
                             input bit ren, input bit pol, input int rel_at,
                             input bit keep_req, input bit scramble);
      int lead_cnt = 0, strb_cnt = 0, tail_cnt = 0, ph = 0, guard = 0;
      bit excl_ok = 1, type_ok = 1, addr_ok = 1, data_ok = 1, cs_ok = 1, first = 1;
      logic [DW-1:0] last_rd = exp_rdata;
      bit strobe_now, wrong_now;
      rdy_en_i  = ren;
      rdy_pol_i = pol;
      if (ren) mem_rb_i = (rel_at != 0) ? pol : ~pol;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(mem_cs_n_o == 1'b1, "R2 idle before request", mem_cs_n_o, 1);
      end
      req_i = 1'b1; we_i = we; addr_i = addr; wdata_i = wd;
      lead_i = ld[2:0]; strobe_i = sb[3:0]; tail_i = tl[2:0];
      forever begin
         @(negedge clk);
         guard++;
         if (first) begin
            check(mem_cs_n_o == 1'b0, "R2 cs low after accept", mem_cs_n_o, 0);
            first = 0;
            if (!keep_req) req_i = 1'b0;
         end
         if (ack_o) begin
            check(mem_cs_n_o == 1'b1, "R7 cs high with ack", mem_cs_n_o, 1);
            req_i = 1'b0;
            bus_drv = 1'b0;
            break;
         end
         if (guard > 300) begin
            check(1'b0, "R10 access never completed", guard, 0);
            req_i = 1'b0;
            break;
         end
         if (mem_cs_n_o) cs_ok = 0;
         if (!mem_oe_n_o && !mem_we_n_o) excl_ok = 0;
         strobe_now = we ? !mem_we_n_o : !mem_oe_n_o;
         wrong_now  = we ? !mem_oe_n_o : !mem_we_n_o;
         if (wrong_now) type_ok = 0;
         if (mem_addr_o !== addr) addr_ok = 0;
         if (we && mem_data_io !== wd) data_ok = 0;
         if (strobe_now) begin
            ph = 1;
            strb_cnt++;
            if (ren && rel_at != 0 && strb_cnt == rel_at) mem_rb_i = ~pol;
         end else if (ph == 0) lead_cnt++;
         else tail_cnt++;
         if (!we && !mem_oe_n_o) begin
            bus_val = DW'($urandom);
            bus_drv = 1'b1;
            last_rd = bus_val;
         end else bus_drv = 1'b0;
         if (!ren) mem_rb_i = $urandom_range(0, 1) == 1;
         if (scramble) begin
            we_i = $urandom_range(0, 1) == 1;
            addr_i = AW'($urandom); wdata_i = DW'($urandom);
            lead_i = 3'($urandom); strobe_i = 4'($urandom); tail_i = 3'($urandom);
            rdy_en_i = $urandom_range(0, 1) == 1; rdy_pol_i = $urandom_range(0, 1) == 1;
         end
      end
      @(negedge clk);
      check(ack_o == 1'b0, "R7 ack one cycle", ack_o, 0);
      check(mem_cs_n_o == 1'b1, "R2 no second access while request held", mem_cs_n_o, 1);
      check(lead_cnt == ld, "R3 lead cycles", lead_cnt, ld);
      check(strb_cnt == exp_strobe_len(sb, ren, rel_at),
            ren ? (pol ? "R11 busy wait strobe" : (rel_at != 0 ? "R10 ready wait strobe" : "R13 ready preset strobe"))
                : "R4 strobe cycles", strb_cnt, exp_strobe_len(sb, ren, rel_at));
      check(tail_cnt == tl, "R5 tail cycles", tail_cnt, tl);
      check(excl_ok && type_ok, "R6 strobe type", type_ok, 1);
      check(cs_ok, "R5 cs stays low", cs_ok, 1);
      check(addr_ok, scramble ? "R12 address captured" : "R9 address held", addr_ok, 1);
      if (we) check(data_ok, scramble ? "R12 write data captured" : "R9 write data driven", data_ok, 1);
      if (!we) exp_rdata = last_rd;
      check(rdata_o === exp_rdata, "R8 read data", rdata_o, exp_rdata);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c1a));
      repeat (3) @(negedge clk);
      check(mem_cs_n_o && mem_oe_n_o && mem_we_n_o, "R1 strobes high in reset", mem_cs_n_o, 1);
      check(ack_o == 1'b0, "R1 ack low in reset", ack_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_access(0, 16'h1234, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);   // R3 R4 R5 zero counts
      run_access(1, 16'hbeef, 16'ha55a, 7, 15, 7, 0, 0, 0, 0, 0); // maxima, R9
      run_access(0, 16'h0042, 16'h0, 3, 5, 2, 1, 0, 12, 0, 0);  // R10 extended
      run_access(1, 16'h7777, 16'h1357, 1, 1, 1, 1, 1, 9, 0, 0); // R11 busy
      run_access(0, 16'h0101, 16'h0, 2, 4, 1, 1, 0, 0, 0, 0);   // R13 ready preset
      run_access(1, 16'h0202, 16'h2468, 0, 3, 0, 1, 1, 0, 0, 0); // R13 busy preset
      run_access(0, 16'h0303, 16'h0, 2, 6, 3, 1, 0, 1, 0, 0);   // R10 early ready
      run_access(0, 16'h0404, 16'h0, 1, 2, 1, 0, 0, 0, 1, 1);   // R12 R2 scramble
      // constrained random
      for (int n = 0; n < 60; n++) begin
         bit ren = $urandom_range(0, 2) == 0;
         run_access($urandom_range(0, 1) == 1, AW'($urandom), DW'($urandom),
                    $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 7),
                    ren, $urandom_range(0, 1) == 1, ren ? $urandom_range(0, 20) : 0,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule